// File: doc/BRIEF.md
# Pipelined Parallel Adder Tree

This block adds N operands of W bits each, all presented together in one clock cycle on a flattened bus, and returns their exact sum. The reduction is a balanced binary tree of two-input adders. Each level adds neighbouring pairs from the level above. If a level has an odd count, its last entry moves down one level with no addition. Pipeline registers sit between adder levels, so a new operand set can enter on every cycle with no stall.

Three parameters set the shape: the operand count (1 to 1024, any value), the operand width, and the number of adder levels grouped between two register stages. Operands are signed two's complement by default; a parameter switches to unsigned. Each level widens its results by one bit, so the sum is W + ceil(log2(N)) bits and cannot overflow. A valid flag travels alongside the data and marks the cycle in which each set's sum appears.

Top module: `adder_tree`

## Requirements
- R1: A full operand set is taken on every cycle with `in_valid` high, and back-to-back sets produce sums on consecutive cycles with no gap and no stall.
- R2: In signed mode (SIGNED_OPS=1), `out_sum` equals the exact two's-complement sum of the N operands, where operand i is `in_ops[i*W +: W]`. The sum is W + ceil(log2(N)) bits wide and does not overflow, even when every operand is the most positive or the most negative value.
- R3: In unsigned mode (SIGNED_OPS=0), each operand is zero-extended and `out_sum` equals the exact unsigned sum.
- R4: The latency from the clock edge that captures a set to the edge that presents its sum is ceil(ceil(log2(N)) / LVLS_PER_STAGE) cycles, or 1 cycle when N = 1.
- R5: `out_valid` is high in exactly those cycles that carry the sum of a set captured with `in_valid` high, and low in every other cycle, including after idle input cycles.
- R6: A synchronous active-high `rst` clears the valid pipeline. `out_valid` is low in the cycle after any reset cycle, and sets that were in flight during reset never show up as valid.
- R7: With N = 1, the block is a single register stage whose `out_sum` equals the one operand.
- R8: An operand count that is not a power of two gives an exact sum: an unpaired entry at a level is carried to the next level at the same latency as the pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks the cycle in which `in_ops` holds a set to sum |
| in_ops | input | N*W | Flattened operands; operand i at bits i*W +: W |
| out_valid | output | 1 | High when `out_sum` holds a finished sum |
| out_sum | output | W+ceil(log2(N)) | Full-precision sum of one operand set |

## Verification
The bench drives three instances: twelve signed bytes with one register per level, five unsigned 6-bit operands with two levels per stage, and a single operand. A design that drops the extra bit per level would wrap the all-most-positive and all-most-negative sets. One that sign-extends in unsigned mode would return negative totals for all-ones operands. Mishandling the odd leftover entry of the five-operand tree would either lose that operand or deliver it one stage late. Isolated valid pulses between idle cycles check that the valid flag matches the data latency exactly. A reset issued while sets are in flight checks that none of them surface afterwards.

// File: rtl/adder_tree_pkg.sv
package adder_tree_pkg;

   // Entries left after `lvl` rounds of pairwise reduction of `n` items.
   function automatic int level_count(input int n, input int lvl);
      int c;
      c = n;
      for (int i = 0; i < lvl; i++) begin
         c = (c + 1) / 2;
      end
      return c;
   endfunction

   // Number of adder levels in a tree over `n` items.
   function automatic int tree_levels(input int n);
      return (n <= 1) ? 0 : $clog2(n);
   endfunction

   // A level ends a register stage when it closes a group or is the last.
   function automatic bit level_registered(input int lvl, input int last,
                                           input int per_stage);
      return ((lvl % per_stage) == 0) || (lvl == last);
   endfunction

   // Register stages between operand capture and the sum.
   function automatic int tree_latency(input int n, input int per_stage);
      int lv;
      lv = tree_levels(n);
      return (lv == 0) ? 1 : (lv + per_stage - 1) / per_stage;
   endfunction

endpackage

// File: rtl/pair_adder.sv
module pair_adder #(
   parameter int W_IN       = 8,
   parameter bit SIGNED_OPS = 1'b1
) (
   input  logic [W_IN-1:0] a,
   input  logic [W_IN-1:0] b,
   output logic [W_IN:0]   sum
);

   logic [W_IN:0] a_ext;
   logic [W_IN:0] b_ext;

   // One guard bit: replicated sign in signed mode, zero otherwise.
   assign a_ext = {SIGNED_OPS & a[W_IN-1], a};
   assign b_ext = {SIGNED_OPS & b[W_IN-1], b};
   assign sum   = a_ext + b_ext;

endmodule

// File: rtl/adder_level.sv
module adder_level #(
   parameter int CNT_IN     = 12,
   parameter int W_IN       = 8,
   parameter bit SIGNED_OPS = 1'b1,
   parameter bit REG_OUT    = 1'b1,
   localparam int CNT_OUT   = (CNT_IN + 1) / 2,
   localparam int W_OUT     = W_IN + 1
) (
   input  logic                     clk,
   input  logic [CNT_IN*W_IN-1:0]   din,
   output logic [CNT_OUT*W_OUT-1:0] dout
);

   for (genvar p = 0; p < CNT_OUT; p++) begin : g_pair
      logic [W_IN-1:0]  op_a;
      logic [W_IN-1:0]  op_b;
      logic [W_OUT-1:0] nxt;

      assign op_a = din[(2*p)*W_IN +: W_IN];

      if (2*p + 1 < CNT_IN) begin : g_full
         assign op_b = din[(2*p+1)*W_IN +: W_IN];
      end else begin : g_odd
         // Leftover entry: adding zero keeps its value and its timing.
         assign op_b = '0;
      end

      pair_adder #(
         .W_IN       (W_IN),
         .SIGNED_OPS (SIGNED_OPS)
      ) u_add (
         .a   (op_a),
         .b   (op_b),
         .sum (nxt)
      );

      if (REG_OUT) begin : g_reg
         logic [W_OUT-1:0] q;
         always_ff @(posedge clk) begin
            q <= nxt;
         end
         assign dout[p*W_OUT +: W_OUT] = q;
      end else begin : g_comb
         assign dout[p*W_OUT +: W_OUT] = nxt;
      end
   end

endmodule

// File: rtl/valid_pipe.sv
module valid_pipe #(
   parameter int DEPTH = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic vin,
   output logic vout
);

   logic [DEPTH-1:0] sr;

   if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
         if (rst) sr <= '0;
         else     sr <= vin;
      end
   end else begin : g_many
      always_ff @(posedge clk) begin
         if (rst) sr <= '0;
         else     sr <= {sr[DEPTH-2:0], vin};
      end
   end

   assign vout = sr[DEPTH-1];

endmodule

// File: rtl/adder_tree.sv
module adder_tree
   import adder_tree_pkg::*;
#(
   parameter int N              = 12,
   parameter int W              = 8,
   parameter int LVLS_PER_STAGE = 1,
   parameter bit SIGNED_OPS     = 1'b1,
   localparam int LEVELS        = tree_levels(N),
   localparam int SUM_W         = W + LEVELS,
   localparam int LAT           = tree_latency(N, LVLS_PER_STAGE)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [N*W-1:0]   in_ops,
   output logic             out_valid,
   output logic [SUM_W-1:0] out_sum
);

   if (N < 1 || N > 1024) begin : g_bad_n
      $error("adder_tree: N must be in 1..1024");
   end
   if (W < 1) begin : g_bad_w
      $error("adder_tree: W must be at least 1");
   end
   if (LVLS_PER_STAGE < 1) begin : g_bad_lps
      $error("adder_tree: LVLS_PER_STAGE must be at least 1");
   end

   valid_pipe #(.DEPTH(LAT)) u_vpipe (
      .clk  (clk),
      .rst  (rst),
      .vin  (in_valid),
      .vout (out_valid)
   );

   if (LEVELS == 0) begin : g_single
      logic [SUM_W-1:0] hold_q;
      always_ff @(posedge clk) begin
         hold_q <= in_ops;
      end
      assign out_sum = hold_q;
   end else begin : g_tree
      for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
         localparam int CI = level_count(N, l - 1);
         localparam int CO = level_count(N, l);
         localparam int WI = W + l - 1;
         localparam bit RG = level_registered(l, LEVELS, LVLS_PER_STAGE);

         logic [CI*WI-1:0]     src;
         logic [CO*(WI+1)-1:0] data;

         if (l == 1) begin : g_src_in
            assign src = in_ops;
         end else begin : g_src_prev
            assign src = g_lvl[l-1].data;
         end

         adder_level #(
            .CNT_IN     (CI),
            .W_IN       (WI),
            .SIGNED_OPS (SIGNED_OPS),
            .REG_OUT    (RG)
         ) u_level (
            .clk  (clk),
            .din  (src),
            .dout (data)
         );
      end
      assign out_sum = g_lvl[LEVELS].data;
   end

endmodule

// File: rtl/adder_tree_chk.sv
module adder_tree_chk #(
   parameter int LAT   = 4,
   parameter int SUM_W = 12
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             out_valid,
   input logic [SUM_W-1:0] out_sum
);

   localparam int CW = $clog2(LAT + 2);

   // Sets accepted but not yet delivered.
   logic [CW-1:0] inflight;

   always_ff @(posedge clk) begin
      if (rst) inflight <= '0;
      else     inflight <= inflight + CW'(in_valid) - CW'(out_valid);
   end

   // R5: never more in flight than pipeline stages
   a_r5_inflight_bound: assert property (@(posedge clk) disable iff (rst)
      inflight <= CW'(LAT));

   // R5: a valid result always belongs to an accepted set
   a_r5_valid_has_source: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (inflight != '0));

   // R6: nothing valid right after reset is released
   a_r6_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !out_valid);

   // R2: a delivered sum is fully defined
   a_r2_sum_defined: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !$isunknown(out_sum));

endmodule

bind adder_tree adder_tree_chk #(
   .LAT   (LAT),
   .SUM_W (SUM_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_sum   (out_sum)
);

// File: tb/tb_adder_tree.sv
module tb_adder_tree;

   // Latencies from R4, worked out here
   localparam int LAT_A = 4;  // N=12: 4 levels, 1 per stage
   localparam int LAT_B = 2;  // N=5: 3 levels, 2 per stage
   localparam int LAT_C = 1;  // N=1

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [95:0] ops = '0;

   logic        va, vb, vc;
   logic [11:0] sa;
   logic [8:0]  sb;
   logic [7:0]  sc;

   always #10 clk = ~clk;  // 50 MHz

   adder_tree #(.N(12), .W(8), .LVLS_PER_STAGE(1), .SIGNED_OPS(1'b1)) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ops(ops),
      .out_valid(va), .out_sum(sa));

   adder_tree #(.N(5), .W(6), .LVLS_PER_STAGE(2), .SIGNED_OPS(1'b0)) dut_u (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ops(ops[29:0]),
      .out_valid(vb), .out_sum(sb));

   adder_tree #(.N(1), .W(8), .LVLS_PER_STAGE(1), .SIGNED_OPS(1'b1)) dut_one (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ops(ops[7:0]),
      .out_valid(vc), .out_sum(sc));

   localparam logic [95:0] VEC [8] = '{
      96'h0,
      {12{8'h7F}},
      {12{8'h80}},
      {12{8'hFF}},
      96'h0102_0304_0506_0708_090A_0B0C,
      {6{16'h7F80}},
      96'hFFFF_FFFF_0000_0000_1234_5678,
      96'hDEAD_BEEF_CAFE_F00D_8001_7FFE
   };

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 1'b0;

   logic        hv_a [256];
   logic        hv_b [256];
   logic        hv_c [256];
   logic [11:0] hs_a [256];
   logic [8:0]  hs_b [256];
   logic [7:0]  hs_c [256];

   function automatic logic [11:0] exp_signed12(input logic [95:0] v);
      int s;
      s = 0;
      for (int i = 0; i < 12; i++) s += int'($signed(v[i*8 +: 8]));
      return 12'(s);
   endfunction

   function automatic logic [8:0] exp_unsigned5(input logic [95:0] v);
      int s;
      s = 0;
      for (int i = 0; i < 5; i++) s += int'(v[i*6 +: 6]);
      return 9'(s);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s cycle=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
      end
   endtask

   task automatic check_outputs();
      int j;
      logic e;
      j = cyc - LAT_A;
      e = (j >= 0) ? hv_a[j % 256] : 1'b0;
      chk("R4 R5 R6 valid N=12", {31'd0, va}, {31'd0, e});
      if (e) chk("R1 R2 sum N=12", {20'd0, sa}, {20'd0, hs_a[j % 256]});
      j = cyc - LAT_B;
      e = (j >= 0) ? hv_b[j % 256] : 1'b0;
      chk("R4 R5 R6 valid N=5", {31'd0, vb}, {31'd0, e});
      if (e) chk("R3 R8 sum N=5", {23'd0, sb}, {23'd0, hs_b[j % 256]});
      j = cyc - LAT_C;
      e = (j >= 0) ? hv_c[j % 256] : 1'b0;
      chk("R7 R5 valid N=1", {31'd0, vc}, {31'd0, e});
      if (e) chk("R7 sum N=1", {24'd0, sc}, {24'd0, hs_c[j % 256]});
   endtask

   task automatic step(input logic r, input logic v, input logic [95:0] d);
      @(negedge clk);
      check_outputs();
      rst = r;
      in_valid = v;
      ops = d;
      hv_a[cyc % 256] = v & ~r;
      hv_b[cyc % 256] = v & ~r;
      hv_c[cyc % 256] = v & ~r;
      hs_a[cyc % 256] = exp_signed12(d);
      hs_b[cyc % 256] = exp_unsigned5(d);
      hs_c[cyc % 256] = d[7:0];
      if (r) begin
         // R6: sets still in flight when reset hits are dropped
         for (int k = 1; k < LAT_A; k++) if (cyc - k >= 0) hv_a[(cyc - k) % 256] = 1'b0;
         for (int k = 1; k < LAT_B; k++) if (cyc - k >= 0) hv_b[(cyc - k) % 256] = 1'b0;
      end
      cyc++;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         hv_a[i] = 1'b0; hv_b[i] = 1'b0; hv_c[i] = 1'b0;
      end
      // Reset cycles: checks of the reset state (R6)
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1, {12{8'h55}});
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0);
      // Vector table, back to back (R1, R2, R3, R8)
      for (int i = 0; i < 8; i++) step(1'b0, 1'b1, VEC[i]);
      for (int i = 0; i < 6; i++) step(1'b0, 1'b0, VEC[7]);
      // Isolated pulses with idle gaps: latency and valid alignment (R4, R5)
      for (int i = 0; i < 4; i++) begin
         step(1'b0, 1'b1, VEC[(i * 3 + 1) % 8]);
         for (int g = 0; g <= i; g++) step(1'b0, 1'b0, VEC[i]);
      end
      for (int i = 0; i < 6; i++) step(1'b0, 1'b0, '0);
      // Reset while sets are in flight (R6)
      for (int i = 0; i < 3; i++) step(1'b0, 1'b1, VEC[i + 1]);
      step(1'b1, 1'b1, VEC[4]);
      for (int i = 0; i < 6; i++) step(1'b0, 1'b0, '0);
      // Extreme operands straight after reset (R2 no overflow, R3 all ones)
      step(1'b0, 1'b1, {12{8'h80}});
      step(1'b0, 1'b1, {12{8'hFF}});
      step(1'b0, 1'b1, {12{8'h7F}});
      step(1'b0, 1'b1, {{66{1'b0}}, {5{6'h3F}}});
      for (int i = 0; i < 8; i++) step(1'b0, 1'b0, '0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule